// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides whether a received CAN frame header is kept and where it goes. A receive path presents each frame's identifier, its extended-format flag, its remote-request flag and the number of the controller instance that received it, with a one-cycle strobe. One cycle later the block reports whether any enabled filter bank accepted the frame, which of the two receive FIFOs the winning bank targets, and that bank's index.

The block holds a parameterised set of filter banks (14 by default). Each bank has two 32-bit words and four control bits: list or mask, 16- or 32-bit scale, FIFO target and enable. At run time one bank is read as four 16-bit exact entries, two 32-bit exact entries, two 16-bit id/mask pairs or a single 32-bit id/mask pair. When several banks accept a frame, the lowest index wins. A split value divides the banks between two controller instances. All configuration goes through a write-only register port, and that port changes nothing while the configuration-lock bit is clear. A single clear write disables every bank of one instance.

Top module: `can_accept_filter`

## Requirements
- R1: After reset the configuration-lock bit reads 0, the split is NUM_BANKS, and every bank has zero words, zero control bits and is disabled. Every frame is rejected.
- R2: res_valid_o is high exactly in the cycle after frame_valid_i was sampled high. In that cycle accept_o, fifo_o and bank_o hold the decision. At all other times, and when a frame is rejected, accept_o, fifo_o and bank_o are 0.
- R3: The 32-bit frame word is {id[10:0], 18'b0, 1'b0, rtr, 1'b0} for a standard frame and {id[28:0], 1'b1, rtr, 1'b0} for an extended frame. A bank with scale=1 and mode=1 accepts a frame whose 32-bit word equals word1 or word2 exactly, the flag bits included.
- R4: A bank with scale=1 and mode=0 accepts a frame when (word & word2) == (word1 & word2).
- R5: The 16-bit frame word is {id[10:0], rtr, 1'b0, 3'b000} for a standard frame and {id[28:18], rtr, 1'b1, id[17:15]} for an extended frame. A bank with scale=0 and mode=1 holds four entries: word1[15:0], word1[31:16], word2[15:0] and word2[31:16]. It accepts a frame whose 16-bit word equals any one of them.
- R6: A bank with scale=0 and mode=0 holds two pairs, each word with the id in [15:0] and the mask in [31:16]. It accepts a frame when either pair matches under its mask. A zero mask accepts every frame.
- R7: A disabled bank never accepts. With no bank enabled, every frame is rejected.
- R8: When several eligible banks accept, bank_o is the lowest of their indices and fifo_o is that bank's FIFO bit.
- R9: Register map by word address: 0 holds the lock bit in bit 0; 1 the split; 2 the mode bits, 3 the scale bits, 4 the FIFO bits and 5 the enable bits (bit b for bank b); 6 the clear command; 8+2b is word1 and 9+2b is word2 of bank b. Address 0 can always be written. Every other write is ignored unless the lock bit is 1.
- R10: A frame presented while the lock bit is 1 gives res_valid_o=1 and accept_o=0.
- R11: A frame with frame_inst_i=0 is checked only against banks below the split. A frame with frame_inst_i=1 is checked only against banks at or above the split.
- R12: A split write with a value above NUM_BANKS is ignored. Any value from 0 to NUM_BANKS is taken.
- R13: A write to address 6 disables every bank of the instance named by wdata[0]: banks 0 to split-1 for instance 0, banks split to NUM_BANKS-1 for instance 1. All other banks keep their state, and an empty range changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| frame_valid_i | input | 1 | Frame header present |
| frame_inst_i | input | 1 | Receiving controller instance |
| frame_ide_i | input | 1 | Extended identifier flag |
| frame_rtr_i | input | 1 | Remote request flag |
| frame_id_i | input | 29 | Identifier; a standard frame uses bits 10:0 |
| res_valid_o | output | 1 | Decision present |
| accept_o | output | 1 | Frame accepted |
| fifo_o | output | 1 | Target FIFO of the winning bank |
| bank_o | output | IDX_W | Index of the winning bank |

## Verification
The assertions assume that frame_inst_i is meaningful only together with frame_valid_i. They also assume that configuration changes arrive only through the write port, so the enable and split state can move only while the lock bit is set. The stimulus changes the configuration only inside lock windows and sends frames only as single-cycle strobes separated by idle cycles, so each decision can be traced to one frame.

The bench keeps its own register image, built only from writes that the map allows. The split sweep runs over every value from 0 to NUM_BANKS for both instances. The frame sweep covers each flag pair against banks of all four layouts.

// File: rtl/can_filt_pkg.sv
`timescale 1ns/1ps
package can_filt_pkg;
  localparam int unsigned REG_CTRL      = 0;
  localparam int unsigned REG_SPLIT     = 1;
  localparam int unsigned REG_MODE      = 2;
  localparam int unsigned REG_SCALE     = 3;
  localparam int unsigned REG_FIFO      = 4;
  localparam int unsigned REG_ENABLE    = 5;
  localparam int unsigned REG_CLEAR     = 6;
  localparam int unsigned REG_BANK_BASE = 8;

  typedef enum logic [1:0] {
    LAY_MASK16 = 2'b00,
    LAY_LIST16 = 2'b01,
    LAY_MASK32 = 2'b10,
    LAY_LIST32 = 2'b11
  } layout_e;

  function automatic logic [31:0] pack_word32(input logic ide, input logic rtr,
                                              input logic [28:0] id);
    return ide ? {id, 1'b1, rtr, 1'b0} : {id[10:0], 18'd0, 1'b0, rtr, 1'b0};
  endfunction

  function automatic logic [15:0] pack_word16(input logic ide, input logic rtr,
                                              input logic [28:0] id);
    return ide ? {id[28:18], rtr, 1'b1, id[17:15]} : {id[10:0], rtr, 1'b0, 3'b000};
  endfunction
endpackage

// File: rtl/can_filt_regs.sv
`timescale 1ns/1ps
module can_filt_regs import can_filt_pkg::*; #(
  parameter int unsigned NUM_BANKS = 14,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned SPLIT_W   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic                      init_o,
  output logic [SPLIT_W-1:0]        split_o,
  output logic [NUM_BANKS-1:0]      mode_o,
  output logic [NUM_BANKS-1:0]      scale_o,
  output logic [NUM_BANKS-1:0]      fifo_o,
  output logic [NUM_BANKS-1:0]      enable_o,
  output logic [NUM_BANKS-1:0][31:0] word1_o,
  output logic [NUM_BANKS-1:0][31:0] word2_o
);
  logic                 cfg_ok;
  logic                 clr_inst;
  logic [NUM_BANKS-1:0] clr_mask;
  int unsigned          clr_start;
  int unsigned          clr_count;

  assign cfg_ok   = we_i && init_o;
  assign clr_inst = wdata_i[0];

  // range of the selected instance, built from start index and bank count
  always_comb begin
    clr_start = clr_inst ? int'(split_o) : 0;
    clr_count = clr_inst ? NUM_BANKS - int'(split_o) : int'(split_o);
    for (int i = 0; i < NUM_BANKS; i++)
      clr_mask[i] = (i >= clr_start) && (i < clr_start + clr_count);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_o   <= 1'b0;
      split_o  <= SPLIT_W'(NUM_BANKS);
      mode_o   <= '0;
      scale_o  <= '0;
      fifo_o   <= '0;
      enable_o <= '0;
    end else begin
      if (we_i && addr_i == ADDR_W'(REG_CTRL)) init_o <= wdata_i[0];
      if (cfg_ok && addr_i == ADDR_W'(REG_SPLIT) && wdata_i <= 32'(NUM_BANKS))
        split_o <= wdata_i[SPLIT_W-1:0];
      if (cfg_ok && addr_i == ADDR_W'(REG_MODE))  mode_o  <= wdata_i[NUM_BANKS-1:0];
      if (cfg_ok && addr_i == ADDR_W'(REG_SCALE)) scale_o <= wdata_i[NUM_BANKS-1:0];
      if (cfg_ok && addr_i == ADDR_W'(REG_FIFO))  fifo_o  <= wdata_i[NUM_BANKS-1:0];
      if (cfg_ok && addr_i == ADDR_W'(REG_ENABLE))
        enable_o <= wdata_i[NUM_BANKS-1:0];
      else if (cfg_ok && addr_i == ADDR_W'(REG_CLEAR))
        enable_o <= enable_o & ~clr_mask;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word1_o[b] <= '0;
        word2_o[b] <= '0;
      end else begin
        if (cfg_ok && addr_i == ADDR_W'(REG_BANK_BASE + 2*b))     word1_o[b] <= wdata_i;
        if (cfg_ok && addr_i == ADDR_W'(REG_BANK_BASE + 2*b + 1)) word2_o[b] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/can_filt_bank_match.sv
`timescale 1ns/1ps
module can_filt_bank_match import can_filt_pkg::*; (
  input  logic        enable_i,
  input  logic        mode_i,
  input  logic        scale_i,
  input  logic [31:0] word1_i,
  input  logic [31:0] word2_i,
  input  logic [31:0] fw32_i,
  input  logic [15:0] fw16_i,
  output logic        hit_o
);
  logic [3:0][15:0] half;
  logic [3:0]       l16_hit;
  logic [1:0]       m16_hit;
  logic             l32_hit;
  logic             m32_hit;
  layout_e          lay;

  assign half = {word2_i, word1_i};

  for (genvar e = 0; e < 4; e++) begin : g_l16
    assign l16_hit[e] = (fw16_i == half[e]);
  end

  // pair p: id in half 2p, mask in half 2p+1
  for (genvar p = 0; p < 2; p++) begin : g_m16
    assign m16_hit[p] = ((fw16_i ^ half[2*p]) & half[2*p+1]) == 16'd0;
  end

  assign l32_hit = (fw32_i == word1_i) || (fw32_i == word2_i);
  assign m32_hit = ((fw32_i ^ word1_i) & word2_i) == 32'd0;
  assign lay     = layout_e'({scale_i, mode_i});

  always_comb begin
    unique case (lay)
      LAY_LIST32: hit_o = l32_hit;
      LAY_MASK32: hit_o = m32_hit;
      LAY_LIST16: hit_o = |l16_hit;
      default:    hit_o = |m16_hit;
    endcase
    hit_o = hit_o && enable_i;
  end
endmodule

// File: rtl/can_filt_prio.sv
`timescale 1ns/1ps
module can_filt_prio #(
  parameter int unsigned N     = 14,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |hit_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit_i[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/can_accept_filter.sv
`timescale 1ns/1ps
module can_accept_filter import can_filt_pkg::*; #(
  parameter  int unsigned NUM_BANKS = 14,
  localparam int unsigned ADDR_W    = $clog2(REG_BANK_BASE + 2*NUM_BANKS),
  localparam int unsigned IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned SPLIT_W   = $clog2(NUM_BANKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              frame_valid_i,
  input  logic              frame_inst_i,
  input  logic              frame_ide_i,
  input  logic              frame_rtr_i,
  input  logic [28:0]       frame_id_i,
  output logic              res_valid_o,
  output logic              accept_o,
  output logic              fifo_o,
  output logic [IDX_W-1:0]  bank_o
);
  logic                       init_q;
  logic [SPLIT_W-1:0]         split_q;
  logic [NUM_BANKS-1:0]       mode_q, scale_q, fifo_q, active_q;
  logic [NUM_BANKS-1:0][31:0] word1_q, word2_q;
  logic [NUM_BANKS-1:0]       hit;
  logic [31:0]                fw32;
  logic [15:0]                fw16;
  logic                       any_hit;
  logic [IDX_W-1:0]           win_idx;

  can_filt_regs #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .SPLIT_W(SPLIT_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .init_o   (init_q),
    .split_o  (split_q),
    .mode_o   (mode_q),
    .scale_o  (scale_q),
    .fifo_o   (fifo_q),
    .enable_o (active_q),
    .word1_o  (word1_q),
    .word2_o  (word2_q)
  );

  assign fw32 = pack_word32(frame_ide_i, frame_rtr_i, frame_id_i);
  assign fw16 = pack_word16(frame_ide_i, frame_rtr_i, frame_id_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic in_range;
    assign in_range = frame_inst_i ? (int'(split_q) <= b) : (int'(split_q) > b);
    can_filt_bank_match u_match (
      .enable_i (active_q[b] && in_range && !init_q),
      .mode_i   (mode_q[b]),
      .scale_i  (scale_q[b]),
      .word1_i  (word1_q[b]),
      .word2_i  (word2_q[b]),
      .fw32_i   (fw32),
      .fw16_i   (fw16),
      .hit_o    (hit[b])
    );
  end

  can_filt_prio #(.N(NUM_BANKS), .IDX_W(IDX_W)) u_prio (
    .hit_i (hit),
    .any_o (any_hit),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      fifo_o      <= 1'b0;
      bank_o      <= '0;
    end else begin
      res_valid_o <= frame_valid_i;
      accept_o    <= frame_valid_i && any_hit;
      fifo_o      <= (frame_valid_i && any_hit) ? fifo_q[win_idx] : 1'b0;
      bank_o      <= (frame_valid_i && any_hit) ? win_idx : '0;
    end
  end
endmodule

// File: rtl/can_filt_chk.sv
`timescale 1ns/1ps
module can_filt_chk #(
  parameter int unsigned NUM_BANKS = 14,
  parameter int unsigned SPLIT_W   = 4,
  parameter int unsigned IDX_W     = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 frame_valid_i,
  input logic                 frame_inst_i,
  input logic                 res_valid_o,
  input logic                 accept_o,
  input logic [IDX_W-1:0]     bank_o,
  input logic                 init_q,
  input logic [SPLIT_W-1:0]   split_q,
  input logic [NUM_BANKS-1:0] active_q
);
  logic [NUM_BANKS-1:0] active_d;
  logic [SPLIT_W-1:0]   split_d;
  logic                 inst_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_d <= '0;
      split_d  <= SPLIT_W'(NUM_BANKS);
      inst_d   <= 1'b0;
    end else begin
      active_d <= active_q;
      split_d  <= split_q;
      inst_d   <= frame_inst_i;
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> res_valid_o); // R2
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !res_valid_o); // R2
  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> res_valid_o); // R2
  AST_INIT_REJECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && init_q) |=> !accept_o); // R10
  AST_LOCKED_CFG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |=> ($stable(active_q) && $stable(split_q))); // R9
  AST_SPLIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(split_q) <= NUM_BANKS); // R12
  AST_WINNER_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> active_d[bank_o]); // R7
  AST_WINNER_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (inst_d ? (int'(bank_o) >= int'(split_d))
                         : (int'(bank_o) <  int'(split_d)))); // R11
endmodule

bind can_accept_filter can_filt_chk #(
  .NUM_BANKS(NUM_BANKS), .SPLIT_W(SPLIT_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_valid_i (frame_valid_i),
  .frame_inst_i  (frame_inst_i),
  .res_valid_o   (res_valid_o),
  .accept_o      (accept_o),
  .bank_o        (bank_o),
  .init_q        (init_q),
  .split_q       (split_q),
  .active_q      (active_q)
);

// File: tb/can_accept_filter_test.sv
`timescale 1ns/1ps
module can_accept_filter_test;
  localparam int NB = 14;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        fv = 1'b0, finst = 1'b0, fide = 1'b0, frtr = 1'b0;
  logic [28:0] fid = '0;
  logic        res_valid, accept, fifo;
  logic [3:0]  bank;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench image of the configuration
  bit          m_init;
  int          m_split;
  logic [NB-1:0] m_mode, m_scale, m_fifo, m_act;
  logic [31:0] m_w1 [NB];
  logic [31:0] m_w2 [NB];

  always #2 clk = ~clk;

  can_accept_filter uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .frame_valid_i(fv), .frame_inst_i(finst),
    .frame_ide_i(fide), .frame_rtr_i(frtr), .frame_id_i(fid),
    .res_valid_o(res_valid), .accept_o(accept), .fifo_o(fifo), .bank_o(bank)
  );

  function automatic logic [31:0] s32(int id, bit rtr);
    return (32'(id) << 21) | (32'(rtr) << 1);
  endfunction
  function automatic logic [31:0] e32(int id, bit rtr);
    return (32'(id) << 3) | 32'h4 | (32'(rtr) << 1);
  endfunction
  function automatic logic [15:0] s16(int id, bit rtr);
    return 16'((id << 5) | (int'(rtr) << 4));
  endfunction

  task automatic model(input bit inst, input bit ide, input bit rtr, input logic [28:0] id,
                       output bit acc, output bit ff, output int bk);
    logic [31:0] w32;
    logic [15:0] w16;
    bit hit;
    acc = 0; ff = 0; bk = 0;
    w32 = ide ? ((32'(id) << 3) | 32'h4 | (32'(rtr) << 1))
              : ((32'(id & 29'h7FF) << 21) | (32'(rtr) << 1));
    w16 = ide ? 16'((((id >> 18) & 29'h7FF) << 5) | (29'(rtr) << 4) | 29'h8 | ((id >> 15) & 29'h7))
              : 16'(((id & 29'h7FF) << 5) | (29'(rtr) << 4));
    if (m_init) return;
    for (int b = NB - 1; b >= 0; b--) begin
      if (!m_act[b]) continue;
      if (inst ? (b < m_split) : (b >= m_split)) continue;
      if (m_scale[b])
        hit = m_mode[b] ? (w32 == m_w1[b] || w32 == m_w2[b])
                        : ((w32 & m_w2[b]) == (m_w1[b] & m_w2[b]));
      else if (m_mode[b])
        hit = (w16 == m_w1[b][15:0]) || (w16 == m_w1[b][31:16]) ||
              (w16 == m_w2[b][15:0]) || (w16 == m_w2[b][31:16]);
      else
        hit = ((w16 & m_w1[b][31:16]) == (m_w1[b][15:0] & m_w1[b][31:16])) ||
              ((w16 & m_w2[b][31:16]) == (m_w2[b][15:0] & m_w2[b][31:16]));
      if (hit) begin acc = 1; ff = m_fifo[b]; bk = b; end
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (a == 0) m_init = d[0];
    else if (m_init) begin
      case (a)
        1: if (d <= NB) m_split = int'(d);
        2: m_mode  = d[NB-1:0];
        3: m_scale = d[NB-1:0];
        4: m_fifo  = d[NB-1:0];
        5: m_act   = d[NB-1:0];
        6: for (int b = 0; b < NB; b++)
             if (d[0] ? (b >= m_split) : (b < m_split)) m_act[b] = 0;
        default:
          if (a >= 8 && a < 8 + 2*NB) begin
            if (a % 2 == 1) m_w2[(a-8)/2] = d; else m_w1[(a-8)/2] = d;
          end
      endcase
    end
  endtask

  task automatic send(input string req, input bit inst, input bit ide, input bit rtr,
                      input logic [28:0] id, input bit ea, input bit ef, input int eb);
    @(negedge clk); fv = 1; finst = inst; fide = ide; frtr = rtr; fid = id;
    @(negedge clk); fv = 0;
    n_chk++;
    if (res_valid !== 1'b1 || accept !== ea || fifo !== (ea ? ef : 1'b0) ||
        int'(bank) != (ea ? eb : 0)) begin
      n_err++;
      $display("FAIL %s inst=%0d ide=%0d rtr=%0d id=%h: valid=%0d accept=%0d fifo=%0d bank=%0d expected valid=1 accept=%0d fifo=%0d bank=%0d",
               req, inst, ide, rtr, id, res_valid, accept, fifo, bank, ea, ea ? ef : 1'b0, ea ? eb : 0);
    end
  endtask

  task automatic send_m(input string req, input bit inst, input bit ide, input bit rtr,
                        input logic [28:0] id);
    bit a, f; int k;
    model(inst, ide, rtr, id, a, f, k);
    send(req, inst, ide, rtr, id, a, f, k);
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    n_chk++;
    if (res_valid !== 1'b0 || accept !== 1'b0) begin
      n_err++;
      $display("FAIL %s idle: valid=%0d accept=%0d expected valid=0 accept=0", req, res_valid, accept);
    end
  endtask

  logic [28:0] ids [12] = '{29'h123, 29'h055, 29'h7FF, 29'h001, 29'h400, 29'h3A5,
                            29'h010, 29'h555, 29'h1ABCDEF, 29'h10ABCDEF, 29'hAAA8000, 29'hAAA0000};

  initial begin
    m_init = 0; m_split = NB; m_mode = '0; m_scale = '0; m_fifo = '0; m_act = '0;
    for (int b = 0; b < NB; b++) begin m_w1[b] = '0; m_w2[b] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 / R2: reset state and result timing
    idle_check("R1");
    send("R1", 0, 0, 0, 29'h123, 0, 0, 0);
    send("R1", 1, 1, 1, 29'h1ABCDEF, 0, 0, 0);
    idle_check("R2");

    // R9: enable write ignored while lock bit clear
    wr(5, 32'h3FFF);
    send("R9", 0, 0, 0, 29'h555, 0, 0, 0);

    // R10: frames during lock rejected; zero-mask bank 0 accepts all afterwards (R6)
    wr(0, 1); wr(5, 32'h1);
    send("R10", 0, 0, 0, 29'h555, 0, 0, 0);
    wr(0, 0);
    send("R6", 0, 1, 1, 29'h1234567, 1, 0, 0);
    send("R9", 0, 0, 0, 29'h555, 1, 0, 0);

    // full configuration: bank0 disabled catch-all, 2 list32, 5 list16, 7 mask16, 9 mask32, 11 catch-all
    wr(0, 1);
    wr(8 + 2*0, 32'h0); wr(9 + 2*0, 32'h0);
    wr(8 + 2*2, s32(12'h123, 0)); wr(9 + 2*2, e32(29'h1ABCDEF, 1));
    wr(8 + 2*5, {s16(1, 1), s16(11'h7FF, 0)});
    wr(9 + 2*5, {16'((11'h2AA << 5) | 8 | 5), s16(11'h400, 0)});
    wr(8 + 2*7, {16'((11'h700 << 5) | 8), s16(11'h300, 0)});
    wr(9 + 2*7, {16'((11'h7FF << 5) | 16), s16(11'h010, 1)});
    wr(8 + 2*9, e32(29'h10000000, 0)); wr(9 + 2*9, (32'h1F000000 << 3) | 32'h4);
    wr(8 + 2*11, 32'h0); wr(9 + 2*11, 32'h0);
    wr(2, (1 << 2) | (1 << 5));
    wr(3, (1 << 0) | (1 << 2) | (1 << 9) | (1 << 11));
    wr(4, (1 << 2) | (1 << 7) | (1 << 11));
    wr(5, (1 << 2) | (1 << 5) | (1 << 7) | (1 << 9) | (1 << 11));
    wr(0, 0);

    send("R3", 0, 0, 0, 29'h123, 1, 1, 2);
    send("R3", 0, 0, 1, 29'h123, 1, 1, 11);
    send("R3", 0, 1, 1, 29'h1ABCDEF, 1, 1, 2);
    send("R3", 0, 1, 0, 29'h1ABCDEF, 1, 1, 11);
    send("R5", 0, 0, 0, 29'h7FF, 1, 0, 5);
    send("R5", 0, 0, 1, 29'h001, 1, 0, 5);
    send("R5", 0, 0, 0, 29'h400, 1, 0, 5);
    send("R5", 0, 1, 0, 29'hAAA8000, 1, 0, 5);
    send("R5", 0, 1, 0, 29'hAAA0000, 1, 1, 11);
    send("R6", 0, 0, 0, 29'h3A5, 1, 1, 7);
    send("R6", 0, 1, 0, 29'h3A5 << 18, 1, 1, 11);
    send("R6", 0, 0, 1, 29'h010, 1, 1, 7);
    send("R6", 0, 0, 0, 29'h010, 1, 1, 11);
    send("R4", 0, 1, 0, 29'h10ABCDEF, 1, 0, 9);
    send("R4", 0, 0, 0, 29'h100, 1, 1, 11);
    send("R7", 0, 0, 0, 29'h555, 1, 1, 11);
    send("R11", 1, 0, 0, 29'h555, 0, 0, 0);

    // sweep flags and ids against the image (R8 priority across overlapping banks)
    for (int i = 0; i < 12; i++)
      for (int f = 0; f < 4; f++)
        send_m("R8", 0, f[1], f[0], ids[i]);

    // R7: nothing enabled
    wr(0, 1); wr(5, 0); wr(0, 0);
    send("R7", 0, 0, 0, 29'h555, 0, 0, 0);
    send("R7", 0, 1, 1, 29'h10ABCDEF, 0, 0, 0);
    wr(0, 1); wr(5, (1 << 2) | (1 << 5) | (1 << 7) | (1 << 9) | (1 << 11)); wr(0, 0);

    // R11: every split value, both instances
    for (int s = 0; s <= NB; s++) begin
      wr(0, 1); wr(1, s); wr(0, 0);
      send("R11", 0, 0, 0, 29'h555, 11 < s, 1, 11);
      send("R11", 1, 0, 0, 29'h555, 11 >= s, 1, 11);
      send_m("R11", 0, 0, 0, 29'h123);
      send_m("R11", 1, 1, 0, 29'h10ABCDEF);
    end

    // R12: out-of-range split ignored
    wr(0, 1); wr(1, 8); wr(1, 15); wr(1, 31); wr(0, 0);
    send("R12", 1, 0, 0, 29'h555, 1, 1, 11);
    send("R12", 0, 0, 0, 29'h7FF, 1, 0, 5);
    send("R12", 0, 1, 0, 29'h10ABCDEF, 0, 0, 0);

    // R13: clear by instance
    wr(0, 1); wr(6, 1); wr(0, 0);
    send("R13", 1, 0, 0, 29'h555, 0, 0, 0);
    send("R13", 0, 0, 0, 29'h123, 1, 1, 2);
    wr(0, 1); wr(6, 0); wr(0, 0);
    send("R13", 0, 0, 0, 29'h123, 0, 0, 0);
    wr(0, 1); wr(5, 32'h3FFF); wr(1, NB); wr(6, 1); wr(0, 0);
    send("R13", 0, 0, 0, 29'h555, 1, 0, 0);
    wr(0, 1); wr(5, 1 << 11); wr(1, 0); wr(6, 0); wr(0, 0);
    send("R13", 1, 0, 0, 29'h555, 1, 1, 11);
    idle_check("R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R2 watchdog: finished=0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule